// File: doc/BRIEF.md
# Disk Controller Command and Status Unit

This block keeps the command word, the disk address word, the CRC holding register and the error and done flags of a 12-bit minicomputer disk controller. The processor reaches it through I/O instructions. Each instruction arrives as a one-cycle strobe with a 3-bit function code and the 12-bit accumulator value. From these the block decodes the clear variants, command load, address load, current-address load, status read, buffer read and flag skip. It produces an accumulator-clear pulse and a skip pulse in the strobe cycle. It drives a level interrupt request and presents a live status word.

Drive conditions are plain level inputs: motor off, write lock, recalibrate in progress, maintenance mode and drive fault. While a recalibrate is running, command and address loads are dropped without notice. A clear or a current-address load in that window is refused and raises a control-busy error together with a status error. While write lock is set, address loads are dropped. The data path owns the CRC arithmetic and hands its result in on `crc_load`. The data path also reports block completion on `xfer_done`. No interface here carries a data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `dsk_ctl_status`

## Requirements
- R1: Reset zeroes command, address, CRC and all flags. With only `motor_off` high after reset, `status_word` reads octal 2200.
- R2: An I/O strobe with function 1 (clear) drives `ac_clear` high in that same cycle for every accumulator value. No other function drives it.
- R3: Clear with `io_ac[1:0]`=00 zeroes done, control-busy error and status-error flags. With all drive inputs low, `status_word` then reads 0.
- R4: Clear with code 01 zeroes the flags and the command word and leaves the address word (sector in bits 3:0, surface in bits 7:4) unchanged.
- R5: Only clear with code 10 zeroes the CRC word. No other clear code, and none of functions 0, 2, 3, 4, 5 or 6, changes it. `crc_load` loads `crc_in`, and a code-10 clear in the same cycle wins.
- R6: Clear with code 11 zeroes flags, command word and address word.
- R7: Function 3 loads the whole accumulator into the address word, which carries both sector and surface, on the next edge. It is ignored while `write_lock` is high.
- R8: While `recal_active` is high, function 2 (command load) and function 3 (address load) change nothing.
- R9: While `recal_active` is high, function 1 or 4 (current-address load) sets control-busy error (status bit 8) and the status-error flag (bit 7), and the clear has no other effect. `recal_active` alone also sets the status-error flag.
- R10: Function 0 asserts `skip` in the strobe cycle when done, control-busy error or status error is set. The status-error term is ignored while `maint_mode` is high.
- R11: `irq` is high whenever control-busy error is set, or when command bit 0 and done are both set.
- R12: A `xfer_done` pulse sets done (status bit 11) on the next edge and wins over a clear in the same cycle. Status bits: 11 done, 10 motor off, 9 write lock, 8 control-busy error, 7 status error (flag or `motor_off` or `drive_fault`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_strobe | input | 1 | One-cycle I/O instruction strobe |
| io_func | input | 3 | Function code of the instruction |
| io_ac | input | 12 | Accumulator value |
| motor_off | input | 1 | Spindle motor not running |
| write_lock | input | 1 | Drive write lock set |
| recal_active | input | 1 | Recalibrate in progress |
| maint_mode | input | 1 | Maintenance mode |
| drive_fault | input | 1 | Live drive fault condition |
| crc_load | input | 1 | Data path writes CRC word |
| crc_in | input | 12 | CRC value from data path |
| xfer_done | input | 1 | Block transfer complete pulse |
| status_word | output | 12 | Live status word |
| cmd_word | output | 12 | Command register |
| addr_word | output | 12 | Disk address register |
| crc_word | output | 12 | CRC holding register |
| ac_clear | output | 1 | Clear accumulator this cycle |
| skip | output | 1 | Skip next instruction this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets each clear code in turn and checks what must survive it. A design with swapped code decode would lose the sector and surface fields on code 01 or leave CRC intact on code 10. Instructions are also issued under recalibrate and write lock. A design that forgot the block would show a changed command or address word, and one that forgot the error would skip no instruction and raise no interrupt. Maintenance mode is toggled with a drive fault present, so that a skip leaking from the status-error term shows as a mismatch. Done is set in the same cycle as a clear, so that wrong priority loses the flag.

// File: rtl/dsk_ctl_pkg.sv
package dsk_ctl_pkg;
  localparam int unsigned WORD_W = 12;
  localparam int unsigned FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_SKIP   = 3'd0,
    FN_CLEAR  = 3'd1,
    FN_LDCMD  = 3'd2,
    FN_LDADDR = 3'd3,
    FN_LDCUR  = 3'd4,
    FN_RDSTAT = 3'd5,
    FN_RDBUF  = 3'd6,
    FN_NONE   = 3'd7
  } io_fn_e;

  typedef struct packed {
    logic clr_flags;
    logic clr_cmd;
    logic clr_addr;
    logic clr_crc;
    logic ld_cmd;
    logic ld_addr;
    logic busy_err;
    logic skip_req;
    logic ac_clear;
  } dec_t;

  localparam int unsigned ST_DONE = 11;
  localparam int unsigned ST_MOTOR = 10;
  localparam int unsigned ST_WLOCK = 9;
  localparam int unsigned ST_BUSY = 8;
  localparam int unsigned ST_SERR = 7;
  localparam int unsigned CMD_IE = 0;
endpackage

// File: rtl/dsk_ctl_decode.sv
module dsk_ctl_decode
  import dsk_ctl_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic                 io_strobe,
  input  logic [FUNC_W-1:0]    io_func,
  input  logic [W-1:0]         io_ac,
  input  logic                 recal_active,
  input  logic                 write_lock,
  output dec_t                 dec
);
  logic [1:0] clr_code;
  logic is_clr, is_cur;

  assign clr_code = io_ac[1:0];
  assign is_clr = io_strobe && (io_func == FN_CLEAR);
  assign is_cur = io_strobe && (io_func == FN_LDCUR);

  always_comb begin
    dec = '0;
    dec.ac_clear = is_clr;
    dec.skip_req = io_strobe && (io_func == FN_SKIP);
    dec.busy_err = recal_active && (is_clr || is_cur);
    if (is_clr && !recal_active) begin
      unique case (clr_code)
        2'b00: dec.clr_flags = 1'b1;
        2'b01: begin dec.clr_flags = 1'b1; dec.clr_cmd = 1'b1; end
        2'b10: dec.clr_crc = 1'b1;
        default: begin dec.clr_flags = 1'b1; dec.clr_cmd = 1'b1; dec.clr_addr = 1'b1; end
      endcase
    end
    dec.ld_cmd  = io_strobe && (io_func == FN_LDCMD) && !recal_active;
    dec.ld_addr = io_strobe && (io_func == FN_LDADDR) && !recal_active && !write_lock;
  end
endmodule

// File: rtl/dsk_ctl_regs.sv
module dsk_ctl_regs
  import dsk_ctl_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dec_t         dec,
  input  logic [W-1:0] io_ac,
  input  logic         crc_load,
  input  logic [W-1:0] crc_in,
  input  logic         recal_active,
  input  logic         write_lock,
  input  logic         io_strobe,
  input  logic [FUNC_W-1:0] io_func,
  output logic [W-1:0] cmd_q,
  output logic [W-1:0] addr_q,
  output logic [W-1:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      crc_q  <= '0;
    end else begin
      if (dec.clr_cmd) cmd_q <= '0;
      else if (dec.ld_cmd) cmd_q <= io_ac;
      if (dec.clr_addr) addr_q <= '0;
      else if (dec.ld_addr) addr_q <= io_ac;
      if (dec.clr_crc) crc_q <= '0;
      else if (crc_load) crc_q <= crc_in;
    end
  end

  assert_addr_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_func == FN_LDADDR && write_lock) |=> $stable(addr_q));
  assert_recal_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_func == FN_LDCMD && recal_active) |=> $stable(cmd_q));
  assert_crc_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!crc_load && !(io_strobe && io_func == FN_CLEAR && io_ac[1:0] == 2'b10))
      |=> $stable(crc_q));
endmodule

// File: rtl/dsk_ctl_flags.sv
module dsk_ctl_flags
  import dsk_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  dec_t dec,
  input  logic recal_active,
  input  logic xfer_done,
  input  logic io_strobe,
  input  logic [FUNC_W-1:0] io_func,
  output logic done_q,
  output logic busy_q,
  output logic serr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      busy_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      if (xfer_done) done_q <= 1'b1;
      else if (dec.clr_flags) done_q <= 1'b0;
      if (dec.busy_err) busy_q <= 1'b1;
      else if (dec.clr_flags) busy_q <= 1'b0;
      if (dec.busy_err || recal_active) serr_q <= 1'b1;
      else if (dec.clr_flags) serr_q <= 1'b0;
    end
  end

  assert_busy_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && recal_active && (io_func == FN_CLEAR || io_func == FN_LDCUR))
      |=> (busy_q && serr_q));
  assert_done_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_q);
endmodule

// File: rtl/dsk_ctl_status.sv
module dsk_ctl_status
  import dsk_ctl_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_strobe,
  input  logic [2:0]    io_func,
  input  logic [W-1:0]  io_ac,
  input  logic          motor_off,
  input  logic          write_lock,
  input  logic          recal_active,
  input  logic          maint_mode,
  input  logic          drive_fault,
  input  logic          crc_load,
  input  logic [W-1:0]  crc_in,
  input  logic          xfer_done,
  output logic [W-1:0]  status_word,
  output logic [W-1:0]  cmd_word,
  output logic [W-1:0]  addr_word,
  output logic [W-1:0]  crc_word,
  output logic          ac_clear,
  output logic          skip,
  output logic          irq
);
  dec_t dec;
  logic done_q, busy_q, serr_q, serr_live;

  dsk_ctl_decode #(.W(W)) u_dec (
    .io_strobe(io_strobe), .io_func(io_func), .io_ac(io_ac),
    .recal_active(recal_active), .write_lock(write_lock), .dec(dec));

  dsk_ctl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .dec(dec), .io_ac(io_ac),
    .crc_load(crc_load), .crc_in(crc_in), .recal_active(recal_active),
    .write_lock(write_lock), .io_strobe(io_strobe), .io_func(io_func),
    .cmd_q(cmd_word), .addr_q(addr_word), .crc_q(crc_word));

  dsk_ctl_flags u_flags (
    .clk(clk), .rst_n(rst_n), .dec(dec), .recal_active(recal_active),
    .xfer_done(xfer_done), .io_strobe(io_strobe), .io_func(io_func),
    .done_q(done_q), .busy_q(busy_q), .serr_q(serr_q));

  assign serr_live = serr_q || motor_off || drive_fault;

  always_comb begin
    status_word = '0;
    status_word[ST_DONE]  = done_q;
    status_word[ST_MOTOR] = motor_off;
    status_word[ST_WLOCK] = write_lock;
    status_word[ST_BUSY]  = busy_q;
    status_word[ST_SERR]  = serr_live;
  end

  assign ac_clear = dec.ac_clear;
  assign skip = dec.skip_req && (done_q || busy_q || (serr_live && !maint_mode));
  assign irq = busy_q || (cmd_word[CMD_IE] && done_q);

  assert_busy_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[ST_BUSY] |-> irq);
  assert_maint_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (skip && maint_mode) |-> (status_word[ST_DONE] || status_word[ST_BUSY]));
  assert_clear_ac_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ac_clear |-> (io_strobe && io_func == 3'd1));
endmodule

// File: tb/dsk_ctl_status_test.sv
`timescale 1ns/1ps
module dsk_ctl_status_test;
  logic clk = 0, rst_n = 0;
  logic io_strobe = 0, motor_off = 0, write_lock = 0, recal_active = 0;
  logic maint_mode = 0, drive_fault = 0, crc_load = 0, xfer_done = 0;
  logic [2:0] io_func = 3'd7;
  logic [11:0] io_ac = '0, crc_in = '0;
  logic [11:0] status_word, cmd_word, addr_word, crc_word;
  logic ac_clear, skip, irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dsk_ctl_status uut (.*);

  // behavioural reference state
  logic [11:0] m_cmd = 0, m_addr = 0, m_crc = 0;
  bit m_done = 0, m_busy = 0, m_serr = 0;

  always @(posedge clk) begin
    bit cf, cc, ca, ccrc;
    cf = 0; cc = 0; ca = 0; ccrc = 0;
    if (!rst_n) begin
      m_cmd = 0; m_addr = 0; m_crc = 0; m_done = 0; m_busy = 0; m_serr = 0;
    end else begin
      if (io_strobe) begin
        if ((io_func == 1 || io_func == 4) && recal_active) begin
          m_busy = 1; m_serr = 1;
        end else if (io_func == 1) begin
          if (io_ac[1:0] == 2) ccrc = 1;
          else begin
            cf = 1; cc = (io_ac[1:0] != 0); ca = (io_ac[1:0] == 3);
          end
        end
        if (io_func == 2 && !recal_active) m_cmd = io_ac;
        if (io_func == 3 && !recal_active && !write_lock) m_addr = io_ac;
      end
      if (cc) m_cmd = 0;
      if (ca) m_addr = 0;
      if (cf) begin
        if (!xfer_done) m_done = 0;
        if (!(io_strobe && recal_active)) m_busy = 0;
        if (!recal_active) m_serr = 0;
      end
      if (xfer_done) m_done = 1;
      if (recal_active) m_serr = 1;
      if (ccrc) m_crc = 0; else if (crc_load) m_crc = crc_in;
    end
  end

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %o expected %o at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against the reference model
  always @(negedge clk) if (rst_n) begin
    bit sl;
    logic [11:0] st;
    sl = m_serr | motor_off | drive_fault;
    st = {m_done, motor_off, write_lock, m_busy, sl, 7'b0};
    chk("R12 status", status_word, st);
    chk("R4 cmd", cmd_word, m_cmd);
    chk("R7 addr", addr_word, m_addr);
    chk("R5 crc", crc_word, m_crc);
    chk("R2 ac_clear", 12'(ac_clear), 12'(io_strobe && io_func == 1));
    chk("R10 skip", 12'(skip),
        12'(io_strobe && io_func == 0 && (m_done | m_busy | (sl & !maint_mode))));
    chk("R11 irq", 12'(irq), 12'(m_busy | (m_cmd[0] & m_done)));
  end

  task automatic issue(input logic [2:0] f, input logic [11:0] ac);
    @(negedge clk); #1; io_strobe = 1; io_func = f; io_ac = ac;
    @(negedge clk); #1; io_strobe = 0; io_func = 3'd7;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    motor_off = 1;
    idle(3); rst_n = 1; idle(2);
    chk("R1 reset status", status_word, 12'o2200);
    chk("R1 reset cmd", cmd_word, 0);
    motor_off = 0;
    issue(1, 12'o0000); idle(1);
    chk("R3 clear00 status", status_word, 0);
    for (int i = 0; i < 12; i++) issue(1, 12'(1 << i) | 12'o0000 & 12'o7774); // R2 sweep
    issue(1, 12'o7777 & 12'o7774);
    issue(2, 12'o0001); issue(3, 12'o0265);
    crc_in = 12'o4321; crc_load = 1; idle(1); crc_load = 0;
    // no-effect ops on CRC and address
    issue(0, 0); issue(4, 12'o1234); issue(5, 0); issue(6, 0);
    issue(1, 12'o0001); idle(1);
    chk("R4 addr kept", addr_word, 12'o0265);
    chk("R5 crc kept", crc_word, 12'o4321);
    issue(1, 12'o0002); idle(1);
    chk("R5 crc cleared", crc_word, 0);
    issue(3, 12'o0377); issue(2, 12'o0401);
    issue(1, 12'o0003); idle(1);
    chk("R6 addr cleared", addr_word, 0);
    chk("R6 cmd cleared", cmd_word, 0);
    write_lock = 1; issue(3, 12'o5555); write_lock = 0; idle(1);
    chk("R7 locked", addr_word, 0);
    issue(3, 12'o0153); idle(1);
    chk("R7 loaded", addr_word, 12'o0153);
    recal_active = 1;
    issue(2, 12'o7777); issue(3, 12'o7000);
    chk("R8 cmd held", cmd_word, 0);
    issue(1, 12'o0003); idle(1);
    chk("R9 busy bit", 12'(status_word[8]), 1);
    chk("R9 addr held", addr_word, 12'o0153);
    recal_active = 0;
    issue(0, 0);
    issue(1, 0); issue(4, 0); // no recal: no error
    recal_active = 1; issue(4, 0); recal_active = 0;
    chk("R9 ldcur busy", 12'(status_word[8]), 1);
    issue(1, 0);
    drive_fault = 1; maint_mode = 1; issue(0, 0);
    maint_mode = 0; issue(0, 0); drive_fault = 0;
    issue(2, 12'o0001);
    @(negedge clk); #1; xfer_done = 1; io_strobe = 1; io_func = 1; io_ac = 0;
    @(negedge clk); #1; xfer_done = 0; io_strobe = 0; io_func = 7;
    chk("R12 done wins", 12'(status_word[11]), 1);
    chk("R11 irq on done", 12'(irq), 1);
    crc_in = 12'o0707; crc_load = 1; issue(1, 12'o0002); crc_load = 0;
    chk("R5 clear beats load", crc_word, 0);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule